// File: doc/BRIEF.md
# External Interrupt Request Latch

This block gathers one active-low external interrupt pin and a small group of port pins into a single pending-interrupt flag. Each port pin takes part only while its own enable bit is set. A mode chosen by a static configuration input decides whether the block reacts only to edges, or also to a sustained active level. The edge sensing is a falling edge on the interrupt pin and a rising edge on a port pin. The level sensing is a low interrupt pin and a high port pin.

The flag drives an interrupt request towards the processor. The request is raised only while a request-enable bit is set and the processor's global interrupt mask is clear. When the request is active, the block presents the address of the vector's high byte (0x0FFA, with the low byte at 0x0FFB). Software can always clear the flag by writing a one to an acknowledge bit. A vector fetch strobe also clears it, but only when a second "hold" enable bit is clear. With the hold bit set, only the explicit acknowledge clears the flag, which lets the service routine tell this source apart from others that share the vector.

Top module: `eirq_latch`

## Requirements
- R1: A synchronous active-high reset clears the flag, the request, the vector output and every enable bit. While reset is held, the sensitivity mode is loaded from `cfg_level` (0 = edge-only, 1 = edge-and-level).
- R2: In either mode, a falling edge on `irq_n` sets the flag. All pins pass through a two-flop synchronizer, so the flag (status bit 3) shows the event on the third rising clock edge after the pin changes.
- R3: A rising edge on port pin i sets the flag only while its enable (status bit 4+i) is set. A port pin whose enable is clear has no effect.
- R4: In edge-and-level mode, the flag is also set on every cycle in which the synchronized `irq_n` is low or any enabled synchronized port pin is high, so an acknowledge cannot clear it while such a level persists.
- R5: In edge-only mode, a level held after its edge does not set the flag again once it has been cleared.
- R6: `irq_req` is registered. It is high one cycle after the flag, the request-enable bit (bit 1) and a clear `cpu_mask` are all present together, and low otherwise.
- R7: A register write with bit 0 set clears the flag, whatever the hold bit holds.
- R8: A `vec_fetch` pulse clears the flag when the hold bit (bit 2) is clear, and leaves it set when the hold bit is set.
- R9: When a set condition and a clear (acknowledge or vector fetch) fall in the same cycle, the flag ends up set.
- R10: `vec_addr` equals 0x0FFA exactly while `irq_req` is high, and is zero otherwise.
- R11: `rd_data` shows bit 0 as zero, bit 1 request enable, bit 2 hold enable, bit 3 the flag, and bits 4 upward the port enables. Writes update bits 1, 2 and 4 upward, and bit 3 cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | 1 | Static mode select, sampled during reset (1 = edge-and-level) |
| irq_n | input | 1 | Asynchronous active-low external interrupt pin |
| port_pin | input | NPORT | Asynchronous port pins, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4+NPORT | Register write data |
| vec_fetch | input | 1 | Strobe for the fetch of this interrupt's vector |
| cpu_mask | input | 1 | Processor global interrupt mask (1 blocks requests) |
| irq_req | output | 1 | Registered interrupt request |
| vec_addr | output | ADDR_W | Vector high-byte address while requesting, else zero |
| rd_data | output | 4+NPORT | Control/status readback |

## Verification
The hardest case to reach is a set condition that lands in the same cycle as a clear. Only the synchronizer delay ties the pin to the internal event, so the bench raises an enabled port pin and waits exactly two falling edges. It then drives the acknowledge write so that it reaches the clock edge at which the detected edge is presented. The level-mode re-set after an acknowledge is reached by holding a pin active across the write. A behavioural model, clocked alongside the design, confirms on every cycle that nothing was lost in either case.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  // control/status register bit positions
  localparam int ACK_BIT   = 0;
  localparam int REQEN_BIT = 1;
  localparam int HOLD_BIT  = 2;
  localparam int FLAG_BIT  = 3;
  localparam int PEN_LSB   = 4;

  typedef enum logic {
    SENS_EDGE       = 1'b0,
    SENS_EDGE_LEVEL = 1'b1
  } sens_mode_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sens_mode_e       mode,
  input  logic             irq_n_s,
  input  logic [NPORT-1:0] port_s,
  input  logic [NPORT-1:0] port_en,
  output logic             set_evt
);
  logic             irq_n_prev;
  logic [NPORT-1:0] port_prev;
  logic [NPORT-1:0] port_hit;
  logic             irq_hit;
  logic             lvl_mode;

  assign lvl_mode = (mode == SENS_EDGE_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_prev <= 1'b1;
      port_prev  <= '0;
    end else begin
      irq_n_prev <= irq_n_s;
      port_prev  <= port_s;
    end
  end

  // pin: falling edge, or low level in level mode
  assign irq_hit = (irq_n_prev & ~irq_n_s) | (lvl_mode & ~irq_n_s);

  // port pins: rising edge, or high level in level mode, gated by enable
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic rise;
    assign rise        = ~port_prev[i] & port_s[i];
    assign port_hit[i] = port_en[i] & (rise | (lvl_mode & port_s[i]));
  end

  assign set_evt = irq_hit | (|port_hit);
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0FFA,
  localparam int REG_W = PEN_LSB + NPORT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_level,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              vec_fetch,
  input  logic              cpu_mask,
  input  logic              set_evt,
  output sens_mode_e        mode,
  output logic [NPORT-1:0]  port_en,
  output logic              req_en,
  output logic              hold_en,
  output logic              flag,
  output logic              ack_wr,
  output logic              irq_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic clr_evt;
  logic req_next;
  logic unused_wr_flag;

  assign unused_wr_flag = wr_data[FLAG_BIT];
  assign ack_wr   = wr_en & wr_data[ACK_BIT];
  assign clr_evt  = ack_wr | (vec_fetch & ~hold_en);
  assign req_next = flag & req_en & ~cpu_mask;

  // mode and enables
  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= sens_mode_e'(cfg_level);
      req_en  <= 1'b0;
      hold_en <= 1'b0;
      port_en <= '0;
    end else if (wr_en) begin
      req_en  <= wr_data[REQEN_BIT];
      hold_en <= wr_data[HOLD_BIT];
      port_en <= wr_data[PEN_LSB +: NPORT];
    end
  end

  // pending flag: set has priority over clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (clr_evt) begin
      flag <= 1'b0;
    end
  end

  // registered request and vector
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      vec_addr <= '0;
    end else begin
      irq_req  <= req_next;
      vec_addr <= req_next ? VEC_ADDR : '0;
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[REQEN_BIT]         = req_en;
    rd_data[HOLD_BIT]          = hold_en;
    rd_data[FLAG_BIT]          = flag;
    rd_data[PEN_LSB +: NPORT]  = port_en;
  end
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch
  import eirq_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0FFA,
  localparam int REG_W = PEN_LSB + NPORT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_level,
  input  logic              irq_n,
  input  logic [NPORT-1:0]  port_pin,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              vec_fetch,
  input  logic              cpu_mask,
  output logic              irq_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic             irq_n_s;
  logic [NPORT-1:0] port_s;
  logic [NPORT-1:0] port_en;
  logic             set_evt;
  logic             req_en;
  logic             hold_en;
  logic             flag;
  logic             ack_wr;
  sens_mode_e       mode;

  eirq_sync #(.W(1), .RST_VAL(1'b1)) u_sync_irq (
    .clk(clk), .rst(rst), .din(irq_n), .dout(irq_n_s)
  );

  eirq_sync #(.W(NPORT), .RST_VAL('0)) u_sync_port (
    .clk(clk), .rst(rst), .din(port_pin), .dout(port_s)
  );

  eirq_detect #(.NPORT(NPORT)) u_detect (
    .clk(clk), .rst(rst), .mode(mode), .irq_n_s(irq_n_s),
    .port_s(port_s), .port_en(port_en), .set_evt(set_evt)
  );

  eirq_ctrl #(.NPORT(NPORT), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .wr_en(wr_en),
    .wr_data(wr_data), .vec_fetch(vec_fetch), .cpu_mask(cpu_mask),
    .set_evt(set_evt), .mode(mode), .port_en(port_en), .req_en(req_en),
    .hold_en(hold_en), .flag(flag), .ack_wr(ack_wr), .irq_req(irq_req),
    .vec_addr(vec_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/eirq_latch_chk.sv
module eirq_latch_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0FFA
) (
  input logic              clk,
  input logic              rst,
  input logic              flag,
  input logic              set_evt,
  input logic              ack_wr,
  input logic              vec_fetch,
  input logic              hold_en,
  input logic              req_en,
  input logic              cpu_mask,
  input logic              irq_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              rd_ack_bit
);
  // R6
  req_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(flag && req_en && !cpu_mask));
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !set_evt) |=> !flag);
  // R8
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && vec_fetch && hold_en && !ack_wr) |=> flag);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);
  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set_evt));
  // R10
  vec_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (vec_addr == VEC_ADDR));
  // R11
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_ack_bit);
endmodule

bind eirq_latch eirq_latch_chk #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst(rst), .flag(flag), .set_evt(set_evt), .ack_wr(ack_wr),
  .vec_fetch(vec_fetch), .hold_en(hold_en), .req_en(req_en),
  .cpu_mask(cpu_mask), .irq_req(irq_req), .vec_addr(vec_addr),
  .rd_ack_bit(rd_data[0])
);

// File: tb/tb_eirq_latch.sv
`timescale 1ns/1ps
module tb_eirq_latch;
  localparam int NPORT = 4;
  localparam int REG_W = 4 + NPORT;

  logic clk = 0;
  logic rst = 1;
  logic cfg_level = 0;
  logic irq_n = 1;
  logic [NPORT-1:0] port_pin = '0;
  logic wr_en = 0;
  logic [REG_W-1:0] wr_data = '0;
  logic vec_fetch = 0;
  logic cpu_mask = 0;
  logic irq_req;
  logic [15:0] vec_addr;
  logic [REG_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eirq_latch dut (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .irq_n(irq_n),
    .port_pin(port_pin), .wr_en(wr_en), .wr_data(wr_data),
    .vec_fetch(vec_fetch), .cpu_mask(cpu_mask), .irq_req(irq_req),
    .vec_addr(vec_addr), .rd_data(rd_data)
  );

  // behavioural reference: pin history by cycle, registers as plain bits
  bit pin_hist_n[$];
  int port_hist[$];
  bit m_lvl, m_flag, m_reqen, m_hold, m_req;
  int m_pen;

  always @(posedge clk) begin
    if (rst) begin
      pin_hist_n = {1'b1, 1'b1, 1'b1};
      port_hist  = {0, 0, 0};
      m_lvl = cfg_level; m_flag = 0; m_reqen = 0; m_hold = 0; m_req = 0; m_pen = 0;
    end else begin
      // synchronized view = value sampled two edges ago; previous = three ago
      bit  cur_n, old_n, set, clr;
      int  cur_p, old_p;
      cur_n = pin_hist_n[1]; old_n = pin_hist_n[0];
      cur_p = port_hist[1];  old_p = port_hist[0];
      set = (old_n && !cur_n) || (m_lvl && !cur_n);
      for (int i = 0; i < NPORT; i++)
        if (m_pen[i] && ((!old_p[i] && cur_p[i]) || (m_lvl && cur_p[i]))) set = 1;
      clr = (wr_en && wr_data[0]) || (vec_fetch && !m_hold);
      m_req = m_flag && m_reqen && !cpu_mask;
      if (set) m_flag = 1; else if (clr) m_flag = 0;
      if (wr_en) begin
        m_reqen = wr_data[1]; m_hold = wr_data[2]; m_pen = int'(wr_data[7:4]);
      end
      void'(pin_hist_n.pop_front()); void'(port_hist.pop_front());
    end
    pin_hist_n.push_back(irq_n);
    port_hist.push_back(int'(port_pin));
    if (rst) begin
      void'(pin_hist_n.pop_front()); void'(port_hist.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      int exp_rd;
      exp_rd = (m_pen << 4) | (int'(m_flag) << 3) | (int'(m_hold) << 2) | (int'(m_reqen) << 1);
      check(irq_req == m_req, "R6 model request", irq_req, m_req);
      check(vec_addr == (m_req ? 16'h0FFA : 16'h0), "R10 model vector", vec_addr,
            m_req ? 16'h0FFA : 0);
      check(int'(rd_data) == exp_rd, "R11 model status", rd_data, exp_rd);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic fetch();
    vec_fetch = 1;
    @(negedge clk);
    vec_fetch = 0;
  endtask

  task automatic do_reset(input bit lvl);
    rst = 1; cfg_level = lvl;
    step(3);
    rst = 0; cfg_level = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset(0);
    // R1: reset state
    check(rd_data == 0, "R1 status after reset", rd_data, 0);
    check(irq_req == 0 && vec_addr == 0, "R1 request after reset", irq_req, 0);

    wr(8'h12);                       // req_en, port0 enabled
    irq_n = 0;                       // R2 falling edge
    step(2);
    check(rd_data[3] == 0, "R2 not yet visible", rd_data[3], 0);
    step(1);
    check(rd_data[3] == 1, "R2 falling edge sets flag", rd_data[3], 1);
    step(1);
    check(irq_req == 1, "R6 request follows flag", irq_req, 1);
    check(vec_addr == 16'h0FFA, "R10 vector address", vec_addr, 16'h0FFA);
    cpu_mask = 1; step(2);
    check(irq_req == 0, "R6 mask blocks request", irq_req, 0);
    cpu_mask = 0;
    fetch();                          // R8 hold clear -> auto clear
    check(rd_data[3] == 0, "R8 fetch clears", rd_data[3], 0);
    step(4);
    check(rd_data[3] == 0, "R5 held low no re-set", rd_data[3], 0);
    irq_n = 1; step(3);

    port_pin[1] = 1; step(4);        // R3 disabled port
    check(rd_data[3] == 0, "R3 disabled port ignored", rd_data[3], 0);
    port_pin[0] = 1; step(3);
    check(rd_data[3] == 1, "R3 enabled port rise", rd_data[3], 1);

    wr(8'h16);                       // hold enable
    fetch(); step(1);
    check(rd_data[3] == 1, "R8 hold keeps flag", rd_data[3], 1);
    wr(8'h17);                       // ack
    check(rd_data[3] == 0, "R7 ack clears with hold", rd_data[3], 0);
    check(rd_data[0] == 0, "R11 ack reads zero", rd_data[0], 0);

    port_pin = '0; step(4);
    port_pin[0] = 1; step(2);        // R9: edge presented at next clock
    wr(8'h17);
    check(rd_data[3] == 1, "R9 set wins over ack", rd_data[3], 1);
    wr(8'h13); step(2);

    // level mode
    port_pin = '0; irq_n = 1;
    do_reset(1);
    check(rd_data == 0, "R1 level reset state", rd_data, 0);
    wr(8'h22);
    irq_n = 0; step(4);
    check(rd_data[3] == 1, "R4 low level sets", rd_data[3], 1);
    wr(8'h23); step(1);
    check(rd_data[3] == 1, "R4 level re-sets after ack", rd_data[3], 1);
    irq_n = 1; step(4);
    wr(8'h23);
    check(rd_data[3] == 0, "R7 ack after level gone", rd_data[3], 0);
    port_pin[1] = 1; step(4);
    wr(8'h23); step(1);
    check(rd_data[3] == 1, "R4 port high level holds", rd_data[3], 1);
    port_pin[0] = 1; step(4);       // port0 disabled in this mode
    port_pin = '0; step(4);
    wr(8'h23); step(2);
    check(rd_data[3] == 0, "R3 cleared once port low", rd_data[3], 0);
    step(4);
    finish_run();
  end
endmodule